// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects an on-chip request port to an external asynchronous static RAM that holds 256K words of 32 bits, organised as four 8-bit lanes that each have their own active-low select. A requester presents an 18-bit word address, a read/write flag, write data and a 4-bit byte mask on a valid/ready handshake. The controller then generates the select, write-enable and output-enable strobes and the data-bus direction, and it holds each phase for a whole number of clock cycles. That number is derived from timing limits in nanoseconds and a clock-period parameter.

A read selects all four lanes with output enable low for long enough to cover the access time. It samples the bus in the last cycle of the access and then waits out the bus release time before the next access. A write selects only the lanes named in the mask, drives the data for the whole pulse and for at least one cycle after it, and raises a done pulse once the write cycle time has elapsed. By default, output enable stays high during writes. A parameter can instead keep it low, and in that mode the pulse is stretched to cover the driver turn-off time plus data setup.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, all lane selects, write enable and output enable are high, the data bus is not driven, `req_ready` is high and neither `rsp_valid` nor `wr_done` is asserted.
- R2: A read holds all four lane selects and output enable low with write enable high for RD = ceil(max(tAA, tRC)/Tclk) cycles, with a minimum of 1. `rsp_valid` is a one-cycle pulse that is visible RD clock edges after the accepting edge, and `rsp_rdata` is the bus value sampled in the last cycle of the access.
- R3: In a write, mask bit i selects lane i, which carries data bits [8i+7:8i]. Only lanes whose mask bit is 1 have their select low, so the other bytes of the word keep their contents, and a mask of 0 leaves the word unchanged.
- R4: Write enable is low for exactly WP = ceil(max(tWP, tDW)/Tclk) cycles. When output-enable-low writes are selected, WP = ceil(max(tWP, tWHZ + tDW)/Tclk) instead, and output enable is held low during the pulse.
- R5: Write data is driven and stable for the whole pulse and for the cycle after it. `wr_done` is a one-cycle pulse that is visible WP + REC clock edges after the accepting edge, where REC = max(1, ceil(tWC/Tclk) - WP).
- R6: The address never changes while any lane select and write enable are both low.
- R7: The controller never drives the bus while the memory outputs are enabled. After a read, it waits at least ceil(tHZ/Tclk) cycles with the memory outputs disabled before it drives again.
- R8: `req_ready` is high only while the controller is idle and is low for the whole of each access, so one request is taken per access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane write mask |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 32 | Read data |
| wr_done | output | 1 | One-cycle write-complete strobe |
| sram_addr | output | 18 | Memory address |
| sram_cs_n | output | 4 | Per-lane select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_o | output | 32 | Data driven towards the memory |
| sram_dq_oe | output | 1 | Bus driver enable for sram_dq_o |
| sram_dq_i | input | 32 | Data returned from the memory |

## Verification
The properties assume that request fields are meaningful only on the accepting edge and that the memory returns settled data by the last read cycle. The stimulus honours both assumptions. It drives each request for exactly one cycle, half a clock away from the edge that takes it, and the behavioural memory puts a junk pattern on the bus until the configured access time has passed. That memory also flags address movement during a write overlap, short or unsteady pulses and bus contention. Two configurations are swept: a fast part with output enable high during writes, and a slow part with output-enable-low writes. In each, every one of the 16 masks is tried at a spread of addresses that includes both ends of the range.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WREC
    } ctl_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        if (ns <= 0) return 0;
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int at_least_one(input int c);
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 32,
    parameter int LANES    = 4,
    parameter int CW       = 2,
    parameter int RD_CYC   = 1,
    parameter int WP_CYC   = 1,
    parameter int WREC_CYC = 1,
    parameter int HZ_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_done,
    input  logic [DATA_W-1:0] dq_i,
    output ctl_state_e        st_nxt,
    output logic [ADDR_W-1:0] addr_nxt,
    output logic [DATA_W-1:0] wdata_nxt,
    output logic [LANES-1:0]  be_nxt
);

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              accept;
    logic              t_zero;
    logic              t_load;
    logic [CW-1:0]     t_val;

    always_comb begin
        st_nxt = state_q;
        accept = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    st_nxt = req_write ? ST_WPULSE : ST_READ;
                end
            end
            ST_READ:   if (t_zero) st_nxt = ST_TURN;
            ST_TURN:   if (t_zero) st_nxt = ST_IDLE;
            ST_WPULSE: if (t_zero) st_nxt = ST_WREC;
            ST_WREC:   if (t_zero) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        case (st_nxt)
            ST_READ:   t_val = CW'(RD_CYC - 1);
            ST_TURN:   t_val = CW'(HZ_CYC - 1);
            ST_WPULSE: t_val = CW'(WP_CYC - 1);
            ST_WREC:   t_val = CW'(WREC_CYC - 1);
            default:   t_val = '0;
        endcase
    end

    assign t_load    = (st_nxt != state_q);
    assign addr_nxt  = accept ? req_addr  : addr_q;
    assign wdata_nxt = accept ? req_wdata : wdata_q;
    assign be_nxt    = accept ? req_be    : be_q;
    assign req_ready = (state_q == ST_IDLE);

    sram_ctl_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            be_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            wr_done   <= 1'b0;
        end else begin
            state_q   <= st_nxt;
            addr_q    <= addr_nxt;
            wdata_q   <= wdata_nxt;
            be_q      <= be_nxt;
            rsp_valid <= (state_q == ST_READ) && t_zero;
            wr_done   <= (state_q == ST_WREC) && t_zero;
            if ((state_q == ST_READ) && t_zero)
                rsp_rdata <= dq_i;
        end
    end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int LANES        = 4,
    parameter int LANE_W       = 8,
    parameter int OE_LOW_WRITE = 0,
    localparam int DATA_W      = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_state_e        st_nxt,
    input  logic [ADDR_W-1:0] addr_nxt,
    input  logic [DATA_W-1:0] wdata_nxt,
    input  logic [LANES-1:0]  be_nxt,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [LANES-1:0]  sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe
);

    localparam logic OE_N_IN_WRITE = (OE_LOW_WRITE != 0) ? 1'b0 : 1'b1;

    logic [LANES-1:0] cs_n_nxt;
    logic             we_n_nxt;
    logic             oe_n_nxt;
    logic             dq_oe_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cs_n_nxt[l] = (st_nxt == ST_READ)   ? 1'b0 :
                             (st_nxt == ST_WPULSE) ? ~be_nxt[l] : 1'b1;
    end

    always_comb begin
        we_n_nxt  = 1'b1;
        oe_n_nxt  = 1'b1;
        dq_oe_nxt = 1'b0;
        case (st_nxt)
            ST_READ:   oe_n_nxt = 1'b0;
            ST_WPULSE: begin
                we_n_nxt  = 1'b0;
                oe_n_nxt  = OE_N_IN_WRITE;
                dq_oe_nxt = 1'b1;
            end
            ST_WREC:   dq_oe_nxt = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr  <= '0;
            sram_cs_n  <= '1;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_dq_o  <= '0;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_addr  <= addr_nxt;
            sram_cs_n  <= cs_n_nxt;
            sram_we_n  <= we_n_nxt;
            sram_oe_n  <= oe_n_nxt;
            sram_dq_o  <= wdata_nxt;
            sram_dq_oe <= dq_oe_nxt;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_AA_NS       = 15,
    parameter int T_RC_NS       = 15,
    parameter int T_WP_NS       = 12,
    parameter int T_WC_NS       = 15,
    parameter int T_DW_NS       = 10,
    parameter int T_WHZ_NS      = 8,
    parameter int T_BUS_HZ_NS   = 8,
    parameter int OE_LOW_WRITE  = 0,
    parameter int ADDR_W        = 18,
    parameter int LANES         = 4,
    parameter int LANE_W        = 8,
    localparam int DATA_W       = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [LANES-1:0]  sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int RD_CYC   = at_least_one(ns_to_cyc(imax(T_AA_NS, T_RC_NS), CLK_PERIOD_NS));
    localparam int WP_NS    = (OE_LOW_WRITE != 0) ? imax(T_WP_NS, T_WHZ_NS + T_DW_NS)
                                                  : imax(T_WP_NS, T_DW_NS);
    localparam int WP_CYC   = at_least_one(ns_to_cyc(WP_NS, CLK_PERIOD_NS));
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int WREC_CYC = at_least_one(WC_CYC - WP_CYC);
    localparam int HZ_CYC   = at_least_one(ns_to_cyc(T_BUS_HZ_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(WREC_CYC, HZ_CYC));
    localparam int CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    ctl_state_e        st_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic [DATA_W-1:0] wdata_nxt;
    logic [LANES-1:0]  be_nxt;

    sram_ctl_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LANES    (LANES),
        .CW       (CW),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .WREC_CYC (WREC_CYC),
        .HZ_CYC   (HZ_CYC)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .wr_done   (wr_done),
        .dq_i      (sram_dq_i),
        .st_nxt    (st_nxt),
        .addr_nxt  (addr_nxt),
        .wdata_nxt (wdata_nxt),
        .be_nxt    (be_nxt)
    );

    sram_ctl_pins #(
        .ADDR_W       (ADDR_W),
        .LANES        (LANES),
        .LANE_W       (LANE_W),
        .OE_LOW_WRITE (OE_LOW_WRITE)
    ) pins_i (
        .clk        (clk),
        .rst        (rst),
        .st_nxt     (st_nxt),
        .addr_nxt   (addr_nxt),
        .wdata_nxt  (wdata_nxt),
        .be_nxt     (be_nxt),
        .sram_addr  (sram_addr),
        .sram_cs_n  (sram_cs_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 4,
    parameter int WP_CYC = 1,
    parameter int RD_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              wr_done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [LANES-1:0]  sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);

    logic [7:0] we_run;
    logic [7:0] oe_run;
    logic       any_sel;

    assign any_sel = (sram_cs_n != {LANES{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= sram_we_n ? 8'd0 : we_run + 8'd1;
            oe_run <= sram_oe_n ? 8'd0 : oe_run + 8'd1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sram_cs_n == {LANES{1'b1}} && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready));

    assert_read_all_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (!sram_oe_n && sram_we_n) |-> (sram_cs_n == '0));

    assert_read_len_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(sram_oe_n) && $past(sram_we_n)) |-> (oe_run == 8'(RD_CYC)));

    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_run == 8'(WP_CYC)));

    assert_data_during_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_dq_oe);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> sram_dq_oe);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done);

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (any_sel && !sram_we_n && $past(any_sel && !sram_we_n)) |-> $stable(sram_addr));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        (any_sel && !sram_oe_n && sram_we_n) |-> !sram_dq_oe);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (any_sel || !sram_we_n || sram_dq_oe) |-> !req_ready);

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .WP_CYC (WP_CYC),
    .RD_CYC (RD_CYC)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .wr_done    (wr_done),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_harness #(
    parameter int PER    = 4,
    parameter int OE_LOW = 0,
    parameter int T_AA   = 15,
    parameter int T_RC   = 15,
    parameter int T_WP   = 12,
    parameter int T_WC   = 15,
    parameter int T_DW   = 10,
    parameter int T_WHZ  = 8,
    parameter int T_HZ   = 8
) (
    input  logic clk,
    input  logic rst,
    output int   n_checks,
    output int   n_errors,
    output logic finished
);

    // expected cycle counts, worked out from the requirement formulas
    localparam int NEED_RD = (T_AA > T_RC) ? T_AA : T_RC;
    localparam int E_RD    = (NEED_RD + PER - 1) / PER;
    localparam int NEED_WP = (OE_LOW != 0) ? ((T_WP > T_WHZ + T_DW) ? T_WP : T_WHZ + T_DW)
                                           : ((T_WP > T_DW) ? T_WP : T_DW);
    localparam int E_WP    = (NEED_WP + PER - 1) / PER;
    localparam int E_WC    = (T_WC + PER - 1) / PER;
    localparam int E_WREC  = (E_WC > E_WP) ? E_WC - E_WP : 1;

    logic        req_valid, req_ready, req_write;
    logic [17:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_be;
    logic        rsp_valid, wr_done;
    logic [31:0] rsp_rdata;
    logic [17:0] sram_addr;
    logic [3:0]  sram_cs_n;
    logic        sram_we_n, sram_oe_n, sram_dq_oe;
    logic [31:0] sram_dq_o;
    logic [31:0] sram_dq_i;

    sram_ctl #(
        .CLK_PERIOD_NS (PER),
        .T_AA_NS       (T_AA),
        .T_RC_NS       (T_RC),
        .T_WP_NS       (T_WP),
        .T_WC_NS       (T_WC),
        .T_DW_NS       (T_DW),
        .T_WHZ_NS      (T_WHZ),
        .T_BUS_HZ_NS   (T_HZ),
        .OE_LOW_WRITE  (OE_LOW)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .wr_done    (wr_done),
        .sram_addr  (sram_addr),
        .sram_cs_n  (sram_cs_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe),
        .sram_dq_i  (sram_dq_i)
    );

    // ---------------- behavioural memory ----------------
    logic [31:0] mem_q   [logic [17:0]];
    logic [31:0] ref_mem [logic [17:0]];
    int v_addr, v_cont, v_data, v_short, v_oe;
    int gap, rcnt, wlen, we_len, last_we_len;
    logic        prev_wr, prev_rd, prev_we_low;
    logic [17:0] prev_addr;
    logic [31:0] wdat_l;
    logic [3:0]  wsel_l;
    logic [17:0] waddr_l;

    function automatic logic [31:0] mem_rd(input logic [17:0] a);
        return mem_q.exists(a) ? mem_q[a] : 32'h0;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [17:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            v_addr = 0; v_cont = 0; v_data = 0; v_short = 0; v_oe = 0;
            gap = 1000; rcnt = 0; wlen = 0; we_len = 0; last_we_len = 0;
            prev_wr = 1'b0; prev_rd = 1'b0; prev_we_low = 1'b0;
            prev_addr = '0; wdat_l = '0; wsel_l = '0; waddr_l = '0;
            sram_dq_i = '0;
        end else begin
            logic [3:0]  sel;
            logic        wr_act, rd_drive;
            logic [31:0] word;
            sel      = ~sram_cs_n;
            wr_act   = (sel != 4'h0) && !sram_we_n;
            rd_drive = (sel != 4'h0) && !sram_oe_n && sram_we_n;

            if (wr_act && prev_wr && sram_addr != prev_addr) begin
                v_addr++; $display("model: address moved during write overlap");
            end
            if (rd_drive && sram_dq_oe) v_cont++;
            if (sram_dq_oe && !rd_drive && gap * PER < T_HZ) v_cont++;
            gap = rd_drive ? 0 : ((gap < 1000) ? gap + 1 : gap);

            if (!sram_we_n) we_len++;
            else if (prev_we_low) begin last_we_len = we_len; we_len = 0; end

            if (wr_act) begin
                if (!sram_dq_oe || (prev_wr && sram_dq_o != wdat_l)) v_data++;
                if (OE_LOW != 0 && sram_oe_n) v_oe++;
                if (!prev_wr) wlen = 0;
                wlen++;
                wdat_l = sram_dq_o; wsel_l = sel; waddr_l = sram_addr;
            end else if (prev_wr) begin
                if (!sram_dq_oe || sram_dq_o != wdat_l) v_data++;
                if (wlen * PER < NEED_WP) v_short++;
                word = mem_rd(waddr_l);
                for (int l = 0; l < 4; l++)
                    if (wsel_l[l]) word[8*l +: 8] = wdat_l[8*l +: 8];
                mem_q[waddr_l] = word;
            end

            if (rd_drive)
                rcnt = (prev_rd && sram_addr == prev_addr) ? rcnt + 1 : 1;
            else
                rcnt = 0;

            if (rd_drive) begin
                word = (rcnt * PER >= T_AA) ? mem_rd(sram_addr) : 32'hA5A5A5A5;
                for (int l = 0; l < 4; l++)
                    if (!sel[l]) word[8*l +: 8] = 8'h00;
                sram_dq_i = word;
            end else begin
                sram_dq_i = 32'h0;
            end

            prev_wr = wr_act; prev_rd = rd_drive; prev_we_low = !sram_we_n;
            prev_addr = sram_addr;
        end
    end

    // ---------------- checks and stimulus ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [17:0] a, input logic [31:0] d,
                         input logic [3:0] be, output int lat, output logic [31:0] rdata);
        int k;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R8", "ready while access under way", {31'h0, req_ready}, 32'h0);
        k = 0;
        while (!(wr ? wr_done : rsp_valid) && k < 64) begin
            @(negedge clk);
            k++;
        end
        lat = k;
        rdata = rsp_rdata;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [31:0] d, input logic [3:0] be);
        int lat;
        logic [31:0] rd, w;
        issue(1'b1, a, d, be, lat, rd);
        check(lat == E_WP + E_WREC, "R5", "write done latency", lat, E_WP + E_WREC);
        check(last_we_len == E_WP, "R4", "write pulse cycles", last_we_len, E_WP);
        w = ref_rd(a);
        for (int l = 0; l < 4; l++)
            if (be[l]) w[8*l +: 8] = d[8*l +: 8];
        ref_mem[a] = w;
    endtask

    task automatic do_read(input logic [17:0] a, input string req);
        int lat;
        logic [31:0] rd;
        issue(1'b0, a, 32'h0, 4'h0, lat, rd);
        check(lat == E_RD, "R2", "read response latency", lat, E_RD);
        check(rd == ref_rd(a), req, "read data", rd, ref_rd(a));
    endtask

    initial begin
        n_checks = 0; n_errors = 0; finished = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
        @(negedge clk);
        // R1: state during reset
        check(sram_cs_n == 4'hF && sram_we_n && sram_oe_n && !sram_dq_oe, "R1",
              "strobes in reset", {25'h0, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 32'h7E);
        check(req_ready && !rsp_valid && !wr_done, "R1", "handshake in reset",
              {29'h0, req_ready, rsp_valid, wr_done}, 32'h4);
        while (rst) @(negedge clk);
        check(sram_cs_n == 4'hF && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready, "R1",
              "idle after reset", {27'h0, sram_cs_n, req_ready}, 32'h1F);
        // fresh memory reads as zero
        do_read(18'h00000, "R2");

        for (int i = 0; i < 10; i++) begin
            logic [17:0] a;
            a = (i == 0) ? 18'h00000 : (i == 1) ? 18'h3FFFF : 18'((i * 37 + i * i * 4099) & 32'h3FFFF);
            do_write(a, {a[15:0], ~a[15:0]}, 4'hF);
            do_read(a, "R2");
            for (int be = 0; be < 16; be++) begin
                logic [31:0] d;
                d = (32'h11223344 * 32'(be + 1)) ^ {14'h0, a};
                do_write(a, d, 4'(be));
                do_read(a, (be == 0) ? "R3_empty_mask" : "R3");
            end
        end
        // back-to-back write right after a read, then read of the neighbour
        do_read(18'h00001, "R2");
        do_write(18'h00001, 32'hCAFEF00D, 4'h5);
        do_read(18'h00001, "R3");

        check(v_addr == 0,  "R6", "address changes in write overlap", v_addr, 0);
        check(v_cont == 0,  "R7", "bus contention or early drive", v_cont, 0);
        check(v_data == 0,  "R5", "unstable or missing write data", v_data, 0);
        check(v_short == 0, "R4", "short write pulses", v_short, 0);
        check(v_oe == 0,    "R4", "output enable not low in write", v_oe, 0);
        finished = 1'b1;
    end

endmodule

module sram_ctl_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   c_fast, e_fast, c_slow, e_slow;
    logic f_fast, f_slow;

    always #10 clk = ~clk;

    // fast grade, output enable high during writes
    sram_ctl_harness #(
        .PER(4), .OE_LOW(0), .T_AA(15), .T_RC(15), .T_WP(12), .T_WC(15),
        .T_DW(10), .T_WHZ(8), .T_HZ(8)
    ) h_fast (.clk(clk), .rst(rst), .n_checks(c_fast), .n_errors(e_fast), .finished(f_fast));

    // slow grade, output enable low during writes (stretched pulse)
    sram_ctl_harness #(
        .PER(7), .OE_LOW(1), .T_AA(20), .T_RC(20), .T_WP(15), .T_WC(20),
        .T_DW(12), .T_WHZ(13), .T_HZ(10)
    ) h_slow (.clk(clk), .rst(rst), .n_checks(c_slow), .n_errors(e_slow), .finished(f_slow));

    initial begin
        int cyc;
        int checks, errors;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!(f_fast === 1'b1 && f_slow === 1'b1) && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        checks = c_fast + c_slow;
        errors = e_fast + e_slow;
        if (!(f_fast === 1'b1 && f_slow === 1'b1)) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule